// File: doc/BRIEF.md
# Shift-Register Audio Frame Sequencer

This block paces the slow modulation units of a sound generator. It runs on the CPU clock and steps its counter on every second cycle. The counter is a 15-bit linear feedback shift register rather than a binary counter. A small decoder watches the register for a handful of fixed states. On those states it issues quarter-frame and half-frame strobes. In one mode it also raises a frame interrupt flag. Envelope, length and sweep units consume the strobes and are not part of the block.

Software writes a two-bit control word. One bit selects the longer five-step sequence and also requests an immediate pair of strobes. The other bit blocks the interrupt. A control write restarts the sequence, but not at once. The restart, and any forced strobes, land on a parity-aligned cycle two or three clocks after the write. A status-read acknowledge clears the interrupt flag.

Cycle numbers below count the first clock after reset release as cycle 0, which is even. A "load" is a reset or a reload of the register with all ones. If a load leaves the register all ones during cycle B, then a step point k ticks later produces its strobes in cycle B+2k+1. Step ticks are 3728, 7456, 11185, 14914 and 18640.

Top module: `lfsr_frame_seq`

## Requirements
- R1: While reset is held, and in cycle 0 after it is released, `qtr_pulse`, `half_pulse` and `frame_irq` are 0. Reset selects four-step mode with the interrupt enabled.
- R2: The register starts from all ones and advances once per odd cycle. The first quarter strobe after reset is in cycle 7457, not in cycle 7456. An all-zero state is never held.
- R3: In four-step mode, relative to a load with base B, quarter strobes occur at B+2k+1 for k = 3728, 7456, 11185 and 14914. Half strobes occur only for k = 7456 and 14914. `half_pulse` is never high without `qtr_pulse`.
- R4: The final step reloads the register, so the next sequence has base B+2K+2. K is 14914 in four-step mode (period 29830 cycles) and 18640 in five-step mode (period 37282 cycles).
- R5: In five-step mode the k = 14914 point produces nothing, and k = 11185 gives a quarter strobe only. k = 18640 gives both strobes, and the interrupt is never raised.
- R6: In four-step mode with the interrupt enabled, `frame_irq` rises in the same cycle as the k = 14914 strobes. It stays high until cleared.
- R7: `irq_ack` high in a cycle clears `frame_irq` from the next cycle. If the flag is being set in that same cycle, the set wins.
- R8: A write with `mode_wdata[0]` = 1 (inhibit) clears `frame_irq` from the next cycle. While inhibit is 1, the flag is not raised.
- R9: A write (`mode_wr` high in cycle w) updates the mode from cycle w+1. It reloads the register at the end of cycle w+3 if w is even, or w+2 if w is odd. The new base is the cycle after the reload.
- R10: A write with `mode_wdata[1]` = 1 (five-step select) also forces both strobes high in the cycle after that reload (w+4 or w+3). It forces them for that one cycle only.
- R11: Outside the events of R3, R5 and R10 both strobes stay low, and each event lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_wr | input | 1 | Control write strobe, one cycle per write |
| mode_wdata | input | 2 | Bit 1: five-step mode and forced strobes; bit 0: interrupt inhibit |
| irq_ack | input | 1 | Status-read acknowledge; clears the frame interrupt |
| qtr_pulse | output | 1 | Quarter-frame strobe, one cycle wide |
| half_pulse | output | 1 | Half-frame strobe, one cycle wide |
| frame_irq | output | 1 | Frame interrupt flag |

## Verification
The register state is visible only through when the strobes land. A wrong feedback tap or starting value moves the first quarter strobe away from cycle 7457. A wrong parity phase shifts every strobe by one cycle at the first step. A reload fault shows up only at the end of a sequence, up to 37282 cycles later, as a wrong period. The bench therefore runs whole sequences in both modes and compares all three outputs against a cycle-counting model on every clock.

// File: rtl/lfsr_frame_seq_pkg.sv
// Package: shared types and elaboration-time helpers for the frame sequencer.
// Assumes a 15-bit register whose feedback is the XOR of its two top stages,
// shifted in at bit 0. Match states are derived by jumping the register
// forward with a GF(2) matrix power, so no long loop runs at elaboration.
package lfsr_frame_seq_pkg;

    localparam int LFSR_W = 15;
    localparam int NSTEPS = 5;

    typedef logic [LFSR_W-1:0]        lfsr_t;
    typedef logic [LFSR_W*LFSR_W-1:0] gf_mat_t;  // column i = image of unit vector i

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_WAIT_EVEN,
        WR_WAIT_ODD
    } wr_state_e;

    // One shift step; an all-zero state takes a forced 1 so it cannot stall.
    function automatic lfsr_t lfsr_next(input lfsr_t s);
        logic fb;
        fb = (s == '0) ? 1'b1 : (s[LFSR_W-1] ^ s[LFSR_W-2]);
        return {s[LFSR_W-2:0], fb};
    endfunction

    // Apply a linear map to a vector.
    function automatic lfsr_t mat_apply(input gf_mat_t m, input lfsr_t v);
        lfsr_t r;
        r = '0;
        for (int i = 0; i < LFSR_W; i++) begin
            if (v[i]) r = r ^ m[i*LFSR_W +: LFSR_W];
        end
        return r;
    endfunction

    // Compose two linear maps: result = a after b.
    function automatic gf_mat_t mat_compose(input gf_mat_t a, input gf_mat_t b);
        gf_mat_t r;
        for (int i = 0; i < LFSR_W; i++) begin
            r[i*LFSR_W +: LFSR_W] = mat_apply(a, b[i*LFSR_W +: LFSR_W]);
        end
        return r;
    endfunction

    // State reached n ticks after loading all ones.
    function automatic lfsr_t lfsr_jump(input int unsigned n);
        gf_mat_t pw;
        gf_mat_t acc;
        for (int i = 0; i < LFSR_W; i++) begin
            pw[i*LFSR_W +: LFSR_W]  = lfsr_next(lfsr_t'(1) << i);
            acc[i*LFSR_W +: LFSR_W] = lfsr_t'(1) << i;
        end
        for (int b = 0; b < 32; b++) begin
            if (n[b]) acc = mat_compose(pw, acc);
            pw = mat_compose(pw, pw);
        end
        return mat_apply(acc, '1);
    endfunction

endpackage

// File: rtl/lfsr_frame_seq_lfsr.sv
// Module: the shift-register counter.
// Advances on tick_i and reloads all ones on reload_i. Assumes reload_i is
// raised only in a tick cycle. Reset loads all ones.
module lfsr_frame_seq_lfsr
    import lfsr_frame_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  reload_i,
    output lfsr_t state_o
);

    lfsr_t state_q;

    // Load, reload or advance the register.
    always_ff @(posedge clk) begin
        if (!rst_n)        state_q <= '1;
        else if (reload_i) state_q <= '1;
        else if (tick_i)   state_q <= lfsr_next(state_q);
    end

    assign state_o = state_q;

    p_reload_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |-> tick_i);

    p_never_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/lfsr_frame_seq_decode.sv
// Module: step-point decoder.
// Compares the register against the states reached after the configured tick
// counts and maps the hits to strobe, final-step and interrupt requests for
// the selected mode. Purely combinational; the caller gates it by phase.
module lfsr_frame_seq_decode
    import lfsr_frame_seq_pkg::*;
#(
    parameter int unsigned STEP1_TICKS = 3728,
    parameter int unsigned STEP2_TICKS = 7456,
    parameter int unsigned STEP3_TICKS = 11185,
    parameter int unsigned STEP4_TICKS = 14914,
    parameter int unsigned STEP5_TICKS = 18640
) (
    input  lfsr_t state_i,
    input  logic  five_step_i,
    output logic  qtr_hit_o,
    output logic  half_hit_o,
    output logic  final_hit_o,
    output logic  irq_hit_o
);

    localparam int unsigned TICKS [NSTEPS] =
        '{STEP1_TICKS, STEP2_TICKS, STEP3_TICKS, STEP4_TICKS, STEP5_TICKS};

    logic [NSTEPS-1:0] hit;

    // One comparator per step point against its precomputed state.
    for (genvar g = 0; g < NSTEPS; g++) begin : g_step
        localparam lfsr_t TARGET = lfsr_jump(TICKS[g]);
        assign hit[g] = (state_i == TARGET);
    end

    // Map step hits to requests for the active mode.
    always_comb begin
        final_hit_o = five_step_i ? hit[4] : hit[3];
        qtr_hit_o   = hit[0] | hit[1] | hit[2] | final_hit_o;
        half_hit_o  = hit[1] | final_hit_o;
        irq_hit_o   = hit[3] & ~five_step_i;
    end

endmodule

// File: rtl/lfsr_frame_seq_wrsync.sv
// Module: cycle parity and delayed write restart.
// Keeps an even/odd phase from reset (first cycle even). A control write arms
// a restart that fires on the first odd cycle after the first even cycle
// following the write. A newer write re-arms it.
module lfsr_frame_seq_wrsync
    import lfsr_frame_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic force_i,
    output logic phase_odd_o,
    output logic wr_reload_o,
    output logic wr_force_o
);

    logic      phase_q;
    logic      force_q;
    wr_state_e st_q;

    // Alternate the phase every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    // Track the pending restart through its even and odd waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= WR_IDLE;
            force_q <= 1'b0;
        end else if (mode_wr) begin
            st_q    <= WR_WAIT_EVEN;
            force_q <= force_i;
        end else begin
            case (st_q)
                WR_WAIT_EVEN: if (!phase_q) st_q <= WR_WAIT_ODD;
                WR_WAIT_ODD:  if (phase_q)  st_q <= WR_IDLE;
                default:                    st_q <= WR_IDLE;
            endcase
        end
    end

    assign phase_odd_o = phase_q;
    assign wr_reload_o = (st_q == WR_WAIT_ODD) && phase_q && !mode_wr;
    assign wr_force_o  = wr_reload_o && force_q;

    p_restart_follows_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload_o |-> ($past(mode_wr, 2) || $past(mode_wr, 3)));

endmodule

// File: rtl/lfsr_frame_seq.sv
// Module: frame sequencer top.
// Holds the control bits, registers the strobes and the interrupt flag, and
// closes the reload loop between decoder and register. Assumes one write per
// restart window and single-cycle acknowledge pulses.
module lfsr_frame_seq
    import lfsr_frame_seq_pkg::*;
#(
    parameter int unsigned STEP1_TICKS = 3728,
    parameter int unsigned STEP2_TICKS = 7456,
    parameter int unsigned STEP3_TICKS = 11185,
    parameter int unsigned STEP4_TICKS = 14914,
    parameter int unsigned STEP5_TICKS = 18640
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    input  logic       irq_ack,
    output logic       qtr_pulse,
    output logic       half_pulse,
    output logic       frame_irq
);

    lfsr_t state;
    logic  phase_odd, wr_reload, wr_force;
    logic  qtr_hit, half_hit, final_hit, irq_hit;
    logic  five_step_q, inhibit_q;
    logic  qtr_q, half_q, final_q, irq_q;
    logic  eval, irq_set, reload;

    lfsr_frame_seq_wrsync u_wrsync (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .force_i     (mode_wdata[1]),
        .phase_odd_o (phase_odd),
        .wr_reload_o (wr_reload),
        .wr_force_o  (wr_force)
    );

    lfsr_frame_seq_lfsr u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (phase_odd),
        .reload_i (reload),
        .state_o  (state)
    );

    lfsr_frame_seq_decode #(
        .STEP1_TICKS (STEP1_TICKS),
        .STEP2_TICKS (STEP2_TICKS),
        .STEP3_TICKS (STEP3_TICKS),
        .STEP4_TICKS (STEP4_TICKS),
        .STEP5_TICKS (STEP5_TICKS)
    ) u_decode (
        .state_i     (state),
        .five_step_i (five_step_q),
        .qtr_hit_o   (qtr_hit),
        .half_hit_o  (half_hit),
        .final_hit_o (final_hit),
        .irq_hit_o   (irq_hit)
    );

    assign eval    = ~phase_odd;
    assign irq_set = eval & irq_hit & ~inhibit_q;
    assign reload  = (phase_odd & final_q) | wr_reload;

    // Capture the control bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            five_step_q <= 1'b0;
            inhibit_q   <= 1'b0;
        end else if (mode_wr) begin
            five_step_q <= mode_wdata[1];
            inhibit_q   <= mode_wdata[0];
        end
    end

    // Register strobes one cycle after a decoded state, or from a forced restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qtr_q   <= 1'b0;
            half_q  <= 1'b0;
            final_q <= 1'b0;
        end else begin
            qtr_q   <= (eval & qtr_hit) | wr_force;
            half_q  <= (eval & half_hit) | wr_force;
            final_q <= eval & final_hit;
        end
    end

    // Interrupt flag: inhibit clears, final step sets, acknowledge clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                       irq_q <= 1'b0;
        else if (mode_wr & mode_wdata[0]) irq_q <= 1'b0;
        else if (irq_set)                 irq_q <= 1'b1;
        else if (irq_ack)                 irq_q <= 1'b0;
    end

    assign qtr_pulse  = qtr_q;
    assign half_pulse = half_q;
    assign frame_irq  = irq_q;

    p_half_with_qtr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        half_pulse |-> qtr_pulse);

    p_irq_rises_on_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_irq) |-> half_pulse);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_set) |=> !frame_irq);

    p_inhibit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_wdata[0]) |=> !frame_irq);

endmodule

// File: tb/lfsr_frame_seq_tb_top.sv
// Bench: cycle-counting reference model, compared on every clock, plus
// directed checks at the cycles the requirements name.
module lfsr_frame_seq_tb_top;

    localparam int T1 = 3728;
    localparam int T2 = 7456;
    localparam int T3 = 11185;
    localparam int T4 = 14914;
    localparam int T5 = 18640;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic       irq_ack = 1'b0;
    logic       qtr_pulse, half_pulse, frame_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Model state
    int    cyc = 0;
    int    base = 0;
    int    pend_at = -1;
    bit    m5 = 0, inh = 0, fin_p = 0, pforce = 0;
    bit    eq = 0, eh = 0, ei = 0, armed = 0;
    string tq = "R1", ti = "R1";

    always #10 clk = ~clk;

    lfsr_frame_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .irq_ack    (irq_ack),
        .qtr_pulse  (qtr_pulse),
        .half_pulse (half_pulse),
        .frame_irq  (frame_irq)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    // Reference model: predicts the outputs of the next cycle.
    always @(posedge clk) begin
        int rel, k, kfin, nb;
        bit nq, nh, nfin, setirq;
        string ntq;
        armed = 1'b1;
        if (!rst_n) begin
            cyc = 0; base = 0; pend_at = -1;
            m5 = 0; inh = 0; fin_p = 0; pforce = 0;
            eq = 0; eh = 0; ei = 0; tq = "R1"; ti = "R1";
        end else begin
            nq = 0; nh = 0; nfin = 0; setirq = 0; ntq = "R11";
            rel = cyc - base;
            if (rel >= 0 && rel % 2 == 0) begin
                k = rel / 2;
                kfin = m5 ? T5 : T4;
                if (k == T1 || k == T2 || k == T3) nq = 1;
                if (k == T2) nh = 1;
                if (k == kfin) begin
                    nq = 1; nh = 1; nfin = 1;
                    if (!m5) setirq = 1;
                end
                if (nq) ntq = m5 ? "R5" : (k == T1 ? "R2" : "R3");
            end
            nb = base;
            if (fin_p) nb = cyc + 1;
            if (pend_at == cyc && !mode_wr) begin
                nb = cyc + 1;
                if (pforce) begin nq = 1; nh = 1; ntq = "R10"; end
                pend_at = -1;
            end
            if (mode_wr && mode_wdata[0]) begin ei = 0; ti = "R8"; end
            else if (setirq && !inh)      begin ei = 1; ti = "R6"; end
            else if (irq_ack)             begin ei = 0; ti = "R7"; end
            if (mode_wr) begin
                m5 = mode_wdata[1];
                inh = mode_wdata[0];
                pforce = mode_wdata[1];
                pend_at = cyc + ((cyc % 2 == 0) ? 3 : 2);
            end
            fin_p = nfin; base = nb;
            eq = nq; eh = nh; tq = ntq;
            cyc++;
        end
    end

    // Compare all outputs against the model on every clock.
    always @(negedge clk) begin
        if (armed && !finished) begin
            chk(tq, "qtr_pulse", int'(qtr_pulse), int'(eq));
            chk(tq, "half_pulse", int'(half_pulse), int'(eh));
            chk(ti, "frame_irq", int'(frame_irq), int'(ei));
        end
    end

    task automatic wait_cycle(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_write(input int w, input logic [1:0] d);
        wait_cycle(w);
        mode_wr = 1'b1; mode_wdata = d;
        @(negedge clk);
        mode_wr = 1'b0; mode_wdata = 2'b00;
    endtask

    task automatic do_ack(input int a);
        wait_cycle(a);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog cycle=%0d actual=running expected=done", cyc);
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "qtr in reset", int'(qtr_pulse), 0);
        chk("R1", "irq in reset", int'(frame_irq), 0);
        rst_n = 1'b1;
        chk("R1", "half at cycle 0", int'(half_pulse), 0);

        wait_cycle(7456); chk("R2", "qtr before step 1", int'(qtr_pulse), 0);
        wait_cycle(7457); chk("R2", "qtr at step 1", int'(qtr_pulse), 1);
                          chk("R3", "half at step 1", int'(half_pulse), 0);
        wait_cycle(2*T2+1); chk("R3", "half at step 2", int'(half_pulse), 1);
        wait_cycle(2*T4+1); chk("R6", "irq at step 4", int'(frame_irq), 1);
        do_ack(29840);
        wait_cycle(29842); chk("R7", "irq after ack", int'(frame_irq), 0);

        wait_cycle(59658); chk("R4", "qtr before second final", int'(qtr_pulse), 0);
        wait_cycle(59659); chk("R4", "half at second final", int'(half_pulse), 1);

        do_write(59700, 2'b01);
        chk("R8", "irq after inhibit write", int'(frame_irq), 0);
        wait_cycle(89533); chk("R9", "qtr after restart", int'(qtr_pulse), 1);
        wait_cycle(89540); chk("R8", "irq while inhibited", int'(frame_irq), 0);

        do_write(89601, 2'b10);
        wait_cycle(89603); chk("R10", "qtr before forced", int'(qtr_pulse), 0);
        wait_cycle(89604); chk("R10", "forced qtr", int'(qtr_pulse), 1);
                           chk("R10", "forced half", int'(half_pulse), 1);
        wait_cycle(89605); chk("R11", "forced qtr width", int'(qtr_pulse), 0);

        wait_cycle(89604+2*T3+1); chk("R5", "step 3 half in five-step", int'(half_pulse), 0);
                                  chk("R5", "step 3 qtr in five-step", int'(qtr_pulse), 1);
        wait_cycle(89604+2*T4+1); chk("R5", "step 4 ignored", int'(qtr_pulse), 0);
        wait_cycle(89604+2*T5+1); chk("R5", "step 5 half", int'(half_pulse), 1);
                                  chk("R5", "no irq in five-step", int'(frame_irq), 0);

        do_write(127000, 2'b00);
        wait_cycle(127004); chk("R9", "no force without bit 1", int'(qtr_pulse), 0);
        wait_cycle(127004+2*T1);   chk("R9", "qtr before new step 1", int'(qtr_pulse), 0);
        wait_cycle(127004+2*T1+1); chk("R9", "qtr at new step 1", int'(qtr_pulse), 1);

        do_ack(127004+2*T4);
        chk("R7", "set wins over ack", int'(frame_irq), 1);
        do_ack(156840);
        wait_cycle(156842); chk("R7", "irq cleared", int'(frame_irq), 0);
        wait_cycle(156850);
        summary();
    end

endmodule